// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This block is the control state machine of a memory that pairs an SRAM array with a nonvolatile shadow copy. It decides when the SRAM contents are copied into the shadow array (a store) and when the shadow array is copied back into the SRAM (a recall). It watches four things: a comparator flag that says whether the storage-capacitor voltage is above the switch threshold, a sampled shared open-drain busy line, and the SRAM chip-enable, write-enable and address inputs. It drives a pull-down enable for the busy line, start pulses for the array model, a chip-disable signal and a gated SRAM write enable.

A rising voltage flag brings the memory up through an automatic recall. A falling flag during operation triggers an automatic store. Any agent on the shared busy line can also request a store by holding the line low. The block then lets SRAM accesses that are in progress finish during a grace window before the store begins. Stores of either kind are skipped when no write has been accepted since the last store or recall. After a store, the memory stays disabled until the busy line is seen high again.

Top module: `nvsram_seq`

## Requirements
- R1: While reset is active, chip_disable is 1 and busy_pull, store_start, recall_start and sram_wr_en are all 0.
- R2: When vcap_ok is sampled 1 while the block is powered down, recall_start pulses high for exactly one cycle. chip_disable stays 1 until recall_done is sampled.
- R3: If vcap_ok drops while a recall is in progress, the recall is abandoned. The next rise of vcap_ok issues a new recall_start pulse.
- R4: If vcap_ok is sampled 0 during normal operation and the dirty flag is set, store_start pulses and a store begins. If the dirty flag is clear, the block powers down with no store.
- R5: busy_pull is 1 from the cycle in which store_start pulses until the cycle after store_done is sampled. It is never 1 outside a store.
- R6: busy_in passes through a two-flop synchronizer. If it is then seen low for more than T_ASSERT consecutive cycles while vcap_ok is 1 and the dirty flag is set, a grace window of T_DELAY cycles opens and a store follows. With stable SRAM inputs, store_start is seen after exactly 3+T_ASSERT+T_DELAY rising edges, counted from the first edge at which busy_in is low.
- R7: Any change on addr_in, ce_in or we_in during the grace window starts the store at the next clock edge.
- R8: sram_wr_en equals ce_in AND we_in in normal operation only. A write attempted during the grace window is suppressed (sram_wr_en 0) and starts the store at the next edge.
- R9: After store_done, chip_disable stays 1 until the synchronized busy line is high. While another agent keeps busy_in low, the block stays disabled.
- R10: The dirty flag is set by every accepted write and cleared when a store or recall completes. When it is clear, a busy-line request produces no store_start and leaves the block running.
- R11: While vcap_ok is 0, a busy-line request produces no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcap_ok | input | 1 | 1 when the storage voltage is above the switch threshold |
| busy_in | input | 1 | Sampled level of the shared open-drain busy line |
| addr_in | input | ADDR_W | SRAM address |
| ce_in | input | 1 | SRAM chip enable |
| we_in | input | 1 | SRAM write enable |
| store_done | input | 1 | Array model finished a store |
| recall_done | input | 1 | Array model finished a recall |
| busy_pull | output | 1 | 1 = pull the busy line low |
| store_start | output | 1 | One-cycle pulse that starts a store |
| recall_start | output | 1 | One-cycle pulse that starts a recall |
| chip_disable | output | 1 | 1 = SRAM access blocked |
| sram_wr_en | output | 1 | Accepted SRAM write strobe |

## Verification
The bench builds the block with T_ASSERT=3, T_DELAY=4 and ADDR_W=4. With these values the full external-request path (synchronizer, hold-off counter and grace window) finishes in ten edges, so its exact cycle count can be checked. The short window also makes it cheap to inject an address change or a write attempt partway through it. The busy line is modelled as a wired AND of busy_pull and a bench-driven external pull. This brings the hold-after-store behaviour of R9 within reach, both with the line released and with the line held low by another agent.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_DOWN,
    ST_RECALL,
    ST_RUN,
    ST_GRACE,
    ST_STORE,
    ST_HOLD
  } nvs_state_e;

  // SRAM access is blocked in every state but normal operation and grace
  function automatic logic blocks_access(nvs_state_e s);
    return (s == ST_DOWN) || (s == ST_RECALL) || (s == ST_STORE) || (s == ST_HOLD);
  endfunction

  // the grace window ends on low voltage, bus activity, a write try or timeout
  function automatic logic grace_over(logic low_v, logic moved, logic wr_try, logic expired);
    return low_v | moved | wr_try | expired;
  endfunction

endpackage

// File: rtl/nvs_sync2.sv
module nvs_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nvs_sat_cnt.sv
module nvs_sat_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic at_lim
);
  localparam int W = $clog2(LIMIT + 2);
  logic [W-1:0] cnt;

  assign at_lim = (cnt == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!at_lim) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty <= 1'b0;
    else if (clr_i) dirty <= 1'b0;
    else if (set_i) dirty <= 1'b1;
  end
endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int T_ASSERT = 16,
  parameter int T_DELAY  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcap_ok,
  input  logic              busy_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ce_in,
  input  logic              we_in,
  input  logic              store_done,
  input  logic              recall_done,
  output logic              busy_pull,
  output logic              store_start,
  output logic              recall_start,
  output logic              chip_disable,
  output logic              sram_wr_en
);
  localparam int BUS_W = ADDR_W + 2;

  nvs_state_e st, nxt;
  logic busy_s;
  logic ext_req, hold_lim, grace_expired;
  logic bus_moved, wr_try;
  logic store_fin, recall_fin;
  logic dirty_q;
  logic [BUS_W-1:0] bus_now, bus_prev;

  nvs_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_in), .q(busy_s)
  );

  // how long the line has been low during normal operation
  nvs_sat_cnt #(.LIMIT(T_ASSERT)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .run((st == ST_RUN) && !busy_s), .at_lim(hold_lim)
  );

  // grace window length
  nvs_sat_cnt #(.LIMIT(T_DELAY - 1)) u_grace_cnt (
    .clk(clk), .rst_n(rst_n), .run(st == ST_GRACE), .at_lim(grace_expired)
  );

  assign bus_now = {addr_in, ce_in, we_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_prev <= '0;
    else        bus_prev <= bus_now;
  end

  assign ext_req    = (st == ST_RUN) && !busy_s && hold_lim;
  assign bus_moved  = (bus_now != bus_prev);
  assign wr_try     = ce_in && we_in;
  assign sram_wr_en = (st == ST_RUN) && wr_try;
  assign store_fin  = (st == ST_STORE) && store_done;
  assign recall_fin = (st == ST_RECALL) && vcap_ok && recall_done;

  nvs_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .set_i(sram_wr_en),
    .clr_i(store_fin || recall_fin), .dirty(dirty_q)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_DOWN:   if (vcap_ok) nxt = ST_RECALL;
      ST_RECALL: begin
        if (!vcap_ok)        nxt = ST_DOWN;
        else if (recall_done) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (!vcap_ok)               nxt = dirty_q ? ST_STORE : ST_DOWN;
        else if (ext_req && dirty_q) nxt = ST_GRACE;
      end
      ST_GRACE:
        if (grace_over(!vcap_ok, bus_moved, wr_try, grace_expired)) nxt = ST_STORE;
      ST_STORE:  if (store_done) nxt = ST_HOLD;
      ST_HOLD:   if (busy_s) nxt = vcap_ok ? ST_RUN : ST_DOWN;
      default:   nxt = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_DOWN;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      st           <= nxt;
      store_start  <= (nxt == ST_STORE) && (st != ST_STORE);
      recall_start <= (nxt == ST_RECALL) && (st != ST_RECALL);
    end
  end

  assign busy_pull    = (st == ST_STORE);
  assign chip_disable = blocks_access(st);

endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_pull,
  input logic store_start,
  input logic recall_start,
  input logic chip_disable,
  input logic sram_wr_en,
  input logic dirty
);
  assert_recall_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |=> !recall_start);

  assert_recall_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> chip_disable);

  assert_store_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);

  assert_store_pulls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> busy_pull);

  assert_pull_from_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull) |-> store_start);

  assert_wr_only_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |-> !chip_disable);

  assert_hold_after_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_pull) |-> chip_disable);

  assert_skip_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> dirty);
endmodule

bind nvsram_seq nvs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_pull(busy_pull), .store_start(store_start),
  .recall_start(recall_start), .chip_disable(chip_disable),
  .sram_wr_en(sram_wr_en), .dirty(dirty_q)
);

// File: tb/tb_nvsram_seq.sv
module tb_nvsram_seq;
  localparam int AW = 4;
  localparam int TA = 3;
  localparam int TD = 4;
  localparam int REQ_EDGES = 3 + TA + TD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcap = 1'b0, ext_low = 1'b0, ce = 1'b0, we = 1'b0, sdone = 1'b0, rdone = 1'b0;
  logic [AW-1:0] addr = '0;
  logic pull, ss, rs, dis, wr;
  wire  busy_line = !(pull || ext_low);
  int   checks = 0, fails = 0;

  always #4 clk = ~clk;

  nvsram_seq #(.ADDR_W(AW), .T_ASSERT(TA), .T_DELAY(TD)) dut (
    .clk(clk), .rst_n(rst_n), .vcap_ok(vcap), .busy_in(busy_line), .addr_in(addr),
    .ce_in(ce), .we_in(we), .store_done(sdone), .recall_done(rdone),
    .busy_pull(pull), .store_start(ss), .recall_start(rs), .chip_disable(dis),
    .sram_wr_en(wr)
  );

  // {vcap, ce, we, rdone, sdone, exp dis, exp rs, exp ss, exp pull, exp wr}
  localparam logic [9:0] VEC [0:15] = '{
    10'b00000_10000, 10'b10000_11000, 10'b10000_10000, 10'b10010_00000,
    10'b00000_10000, 10'b10000_11000, 10'b10010_00000, 10'b11100_00001,
    10'b10000_00000, 10'b00000_10110, 10'b00000_10010, 10'b00001_10000,
    10'b10000_10000, 10'b10000_10000, 10'b10000_00000, 10'b10000_00000
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_write();
    @(negedge clk); ce = 1'b1; we = 1'b1; addr = addr + 1'b1;
    cyc();
    @(negedge clk); ce = 1'b0; we = 1'b0;
    cyc(); cyc(); cyc();
  endtask

  task automatic ext_no_store(input string req, input logic exp_dis);
    int seen = 0;
    @(negedge clk); ext_low = 1'b1;
    for (int i = 0; i < 12; i++) begin
      cyc();
      if (ss || pull || dis != exp_dis) seen++;
    end
    chk(seen == 0, req, seen, 0);
    @(negedge clk); ext_low = 1'b0;
    cyc(); cyc(); cyc(); cyc();
  endtask

  task automatic finish_store(input string req);
    @(negedge clk); sdone = 1'b1;
    cyc();
    @(negedge clk); sdone = 1'b0; ext_low = 1'b0;
    cyc(); cyc(); cyc();
    chk(dis == 1'b0, req, dis, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk({dis, pull, ss, rs, wr} == 5'b10000, "R1 reset", {dis, pull, ss, rs, wr}, 5'b10000);
    @(negedge clk); rst_n = 1'b1;

    // table: power-up recall, clean drop, write, dirty drop with store, hold
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {vcap, ce, we, rdone, sdone} = VEC[i][9:5];
      cyc();
      chk({dis, rs, ss, pull, wr} == VEC[i][4:0],
          $sformatf("R2/R4/R5/R9 vector %0d", i), {dis, rs, ss, pull, wr}, VEC[i][4:0]);
    end
    @(negedge clk); rdone = 1'b0; sdone = 1'b0; ce = 1'b0; we = 1'b0;
    cyc(); cyc();

    // R10: clean memory ignores a busy-line request
    ext_no_store("R10 clean request", 1'b0);

    // R6: timed request, R5 line held, R9 held disabled by another agent
    do_write();
    @(negedge clk); ext_low = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(); n++;
      if (ss) break;
    end
    chk(n == REQ_EDGES, "R6 request latency", n, REQ_EDGES);
    chk(pull == 1'b1, "R5 pull at start", pull, 1);
    cyc(); cyc();
    chk(pull == 1'b1 && ss == 1'b0, "R5 pull during store", pull, 1);
    @(negedge clk); sdone = 1'b1;
    cyc();
    chk(pull == 1'b0 && dis == 1'b1, "R5 release after done", pull, 0);
    @(negedge clk); sdone = 1'b0;
    n = 0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      if (!dis) n++;
    end
    chk(n == 0, "R9 held low by other agent", n, 0);
    @(negedge clk); ext_low = 1'b0;
    cyc(); cyc();
    chk(dis == 1'b1, "R9 still disabled in sync", dis, 1);
    cyc();
    chk(dis == 1'b0, "R9 enabled after line high", dis, 0);

    // R10: dirty cleared by the completed store
    ext_no_store("R10 cleared after store", 1'b0);

    // R7: address change inside the grace window
    do_write();
    @(negedge clk); ext_low = 1'b1;
    n = 0;
    for (int i = 0; i < 3 + TA; i++) begin
      cyc();
      if (ss) n++;
    end
    chk(n == 0, "R7 no store before change", n, 0);
    @(negedge clk); addr = addr + 1'b1;
    cyc();
    chk(ss == 1'b1, "R7 store on address change", ss, 1);
    finish_store("R7 recovery");

    // R8: write attempt inside the grace window
    do_write();
    @(negedge clk); ext_low = 1'b1;
    for (int i = 0; i < 3 + TA; i++) cyc();
    @(negedge clk); ce = 1'b1; we = 1'b1;
    #1;
    chk(wr == 1'b0, "R8 write suppressed", wr, 0);
    cyc();
    chk(ss == 1'b1, "R8 store on write attempt", ss, 1);
    @(negedge clk); ce = 1'b0; we = 1'b0;
    finish_store("R8 recovery");

    // R11: low voltage blocks requests (clean drop powers down)
    @(negedge clk); vcap = 1'b0;
    cyc();
    chk(dis == 1'b1 && ss == 1'b0, "R4 clean drop no store", ss, 0);
    ext_no_store("R11 request while low", 1'b1);

    // R2 then R3: recall abandoned and reissued
    @(negedge clk); vcap = 1'b1;
    cyc();
    chk(rs == 1'b1, "R2 recall on rise", rs, 1);
    @(negedge clk); vcap = 1'b0;
    cyc();
    chk(rs == 1'b0 && dis == 1'b1, "R3 drop during recall", rs, 0);
    @(negedge clk); vcap = 1'b1;
    cyc();
    chk(rs == 1'b1, "R3 recall reissued", rs, 1);
    @(negedge clk); rdone = 1'b1;
    cyc();
    chk(dis == 1'b0, "R2 enabled after recall", dis, 0);
    @(negedge clk); rdone = 1'b0;
    cyc();

    summary();
  end
endmodule